// File: doc/BRIEF.md
# Burst Address Sequencer

This block forms the internal word address for a synchronous memory that supports four-beat bursts. On a rising clock edge, either of two active-low address strobes can capture an external address while the chip is selected. The capture has two parts: a high field and a 2-bit low field. After the capture, the high field stays fixed. The low field is handed to a small offset counter, which steps once per clock edge while the active-low advance input is held low.

The counter follows one of two orders, chosen by a static order-select input. When the input is low, the offset counts up and wraps modulo four. When it is high, the offset is the starting offset XORed with a running step count of 0, 1, 2, 3. A new address may be loaded on any cycle, so a controller that never uses bursts can simply strobe every cycle. The address output is registered and changes on the clock edge that samples the request.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `word_addr` becomes all zeros on that edge.
- R2: When `strobe_cpu_n` is low and the chip is selected (`ce` high and `ce_n` low), `word_addr` equals {`hi_addr`, `lo_addr`} after that edge.
- R3: When `strobe_ctl_n` is low and the chip is selected, `word_addr` equals {`hi_addr`, `lo_addr`} after that edge.
- R4: With `order_sel` low (linear), each advance edge sets the low two bits to the previous low two bits plus one, modulo 4.
- R5: With `order_sel` high (interleaved), the n-th advance after a load gives low bits equal to the loaded offset XOR (n mod 4).
- R6: With both strobes high and `adv_n` high, `word_addr` keeps its value.
- R7: A strobe that loads takes priority over `adv_n` low in the same cycle.
- R8: With no strobe asserted, the high field `word_addr[HI_W+1:2]` keeps its value.
- R9: A strobe while the chip is deselected (`ce` low or `ce_n` high) loads nothing, and `word_addr` keeps its value.
- R10: Four advances after a load bring the low bits back to the loaded offset, in either order.
- R11: Loads on consecutive cycles each take effect, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_addr | input | HI_W | High address field, captured on load |
| lo_addr | input | 2 | Low address field, start offset of the burst |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce | input | 1 | Chip enable, active high |
| ce_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| word_addr | output | HI_W+2 | Registered internal word address |

## Verification
If the start offset or the step count were corrupted inside, the damage would reach `word_addr` on the next advance edge. The damage would then persist through the rest of the burst, so a wrapped fourth beat that does not return to the loaded offset exposes it. A wrong high-field register shows up right away, on the first edge after a load. A fault in the select or priority decode shows up on the very edge of the offending request, as a load that is missing or unwanted. Each stimulus cycle is therefore compared one edge later against a model of the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // order_sel encoding: 0 = linear wrap, 1 = interleaved XOR
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic load;
    logic step;
  } seq_cmd_t;
endpackage

// File: rtl/bs_ctrl.sv
module bs_ctrl
  import burst_seq_pkg::*;
(
  input  logic     strobe_cpu_n,
  input  logic     strobe_ctl_n,
  input  logic     adv_n,
  input  logic     ce,
  input  logic     ce_n,
  output seq_cmd_t cmd
);
  logic any_strobe;
  logic selected;

  always_comb begin
    any_strobe = ~strobe_cpu_n | ~strobe_ctl_n;
    selected   = ce & ~ce_n;
    // a strobe wins over advance; a deselected strobe is a no-op cycle
    cmd.load   = any_strobe & selected;
    cmd.step   = ~any_strobe & ~adv_n;
  end
endmodule

// File: rtl/bs_hi_reg.sv
module bs_hi_reg #(
  parameter int HI_W = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst)       hi_q <= '0;
    else if (load) hi_q <= hi_in;
  end
endmodule

// File: rtl/bs_counter.sv
module bs_counter
  import burst_seq_pkg::*;
#(
  parameter int LO_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic [LO_W-1:0] preset,
  input  burst_order_e    order,
  output logic [LO_W-1:0] offs_q
);
  logic [LO_W-1:0] start_q;
  logic [LO_W-1:0] cnt_q;
  logic [LO_W-1:0] cnt_inc;
  logic [LO_W-1:0] offs_step;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    if (order == ORD_XOR) offs_step = start_q ^ cnt_inc;
    else                  offs_step = start_q + cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cnt_q   <= '0;
      offs_q  <= '0;
    end else if (load) begin
      start_q <= preset;
      cnt_q   <= '0;
      offs_q  <= preset;
    end else if (step) begin
      cnt_q   <= cnt_inc;
      offs_q  <= offs_step;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int HI_W = 17,
  parameter int LO_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HI_W-1:0]      hi_addr,
  input  logic [LO_W-1:0]      lo_addr,
  input  logic                 strobe_cpu_n,
  input  logic                 strobe_ctl_n,
  input  logic                 adv_n,
  input  logic                 ce,
  input  logic                 ce_n,
  input  logic                 order_sel,
  output logic [HI_W+LO_W-1:0] word_addr
);
  localparam int AW = HI_W + LO_W;

  seq_cmd_t        cmd;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] offs_q;
  burst_order_e    order;

  assign order = burst_order_e'(order_sel);

  bs_ctrl u_ctrl (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .ce           (ce),
    .ce_n         (ce_n),
    .cmd          (cmd)
  );

  bs_hi_reg #(.HI_W(HI_W)) u_hi (
    .clk   (clk),
    .rst   (rst),
    .load  (cmd.load),
    .hi_in (hi_addr),
    .hi_q  (hi_q)
  );

  bs_counter #(.LO_W(LO_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (cmd.load),
    .step   (cmd.step),
    .preset (lo_addr),
    .order  (order),
    .offs_q (offs_q)
  );

  assign word_addr = AW'({hi_q, offs_q});
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int HI_W = 17,
  parameter int LO_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [HI_W-1:0]      hi_addr,
  input logic [LO_W-1:0]      lo_addr,
  input logic                 strobe_cpu_n,
  input logic                 strobe_ctl_n,
  input logic                 adv_n,
  input logic                 ce,
  input logic                 ce_n,
  input logic                 order_sel,
  input logic [HI_W+LO_W-1:0] word_addr
);
  logic sel;
  logic nostb;
  assign sel   = ce & ~ce_n;
  assign nostb = strobe_cpu_n & strobe_ctl_n;

  p_reset_r1: assert property (@(posedge clk) rst |=> word_addr == '0);

  p_load_cpu_r2: assert property (@(posedge clk) disable iff (rst)
    (sel && !strobe_cpu_n) |=> word_addr == {$past(hi_addr), $past(lo_addr)});

  p_load_ctl_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && !strobe_ctl_n) |=> word_addr == {$past(hi_addr), $past(lo_addr)});

  p_lin_step_r4: assert property (@(posedge clk) disable iff (rst)
    (nostb && !adv_n && !order_sel)
      |=> word_addr[LO_W-1:0] == LO_W'($past(word_addr[LO_W-1:0]) + 1'b1));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (nostb && adv_n) |=> $stable(word_addr));

  p_hi_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    nostb |=> $stable(word_addr[HI_W+LO_W-1:LO_W]));

  p_desel_r9: assert property (@(posedge clk) disable iff (rst)
    (!sel && !nostb) |=> $stable(word_addr));
endmodule

bind burst_addr_seq bs_checker #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .hi_addr      (hi_addr),
  .lo_addr      (lo_addr),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .adv_n        (adv_n),
  .ce           (ce),
  .ce_n         (ce_n),
  .order_sel    (order_sel),
  .word_addr    (word_addr)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int PERIOD = 10;
  localparam int HI_W   = 17;
  localparam int AW     = HI_W + 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [HI_W-1:0] hi_addr;
  logic [1:0]      lo_addr;
  logic            strobe_cpu_n, strobe_ctl_n, adv_n, ce, ce_n, order_sel;
  logic [AW-1:0]   word_addr;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;
  item_t q[$];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [HI_W-1:0] m_hi;
  logic [1:0]      m_start, m_lo;
  int              m_n;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq #(.HI_W(HI_W), .LO_W(2)) u0 (
    .clk(clk), .rst(rst), .hi_addr(hi_addr), .lo_addr(lo_addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .ce(ce), .ce_n(ce_n), .order_sel(order_sel), .word_addr(word_addr)
  );

  // monitor: one expected item per edge, compared just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (word_addr !== it.exp) begin
        n_fail++;
        $display("FAIL %s: word_addr=%h expected=%h", it.tag, word_addr, it.exp);
      end
    end
  end

  task automatic drive(input logic r, input logic cpu_n, input logic ctl_n,
                       input logic a_n, input logic e, input logic e_n,
                       input logic ord, input logic [HI_W-1:0] hi,
                       input logic [1:0] lo, input string tag);
    item_t it;
    logic  sel, anys;
    @(negedge clk);
    rst = r; strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; adv_n = a_n;
    ce = e; ce_n = e_n; order_sel = ord; hi_addr = hi; lo_addr = lo;
    sel  = e & ~e_n;
    anys = ~cpu_n | ~ctl_n;
    if (r) begin
      m_hi = '0; m_start = '0; m_lo = '0; m_n = 0;
    end else if (anys && sel) begin
      m_hi = hi; m_start = lo; m_lo = lo; m_n = 0;
    end else if (!anys && !a_n) begin
      m_n = (m_n + 1) % 4;
      if (ord) m_lo = m_start ^ 2'(m_n);
      else     m_lo = m_lo + 2'd1;
    end
    it.exp = {m_hi, m_lo};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expired, expected end of stimulus");
      finish_up();
    end
  end

  initial begin
    rst = 1; strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    ce = 1; ce_n = 0; order_sel = 1; hi_addr = '0; lo_addr = '0;
    drive(1,1,1,1,1,0,1,'0,2'd0,"R1 reset");
    drive(1,1,1,1,1,0,1,17'h1ffff,2'd3,"R1 reset");
    // R2 processor strobe load, interleaved order
    drive(0,0,1,1,1,0,1,17'h01234,2'd1,"R2 cpu load");
    // R5 interleaved steps: 0,3,2 ; R8 high fixed
    drive(0,1,1,0,1,0,1,17'h00000,2'd0,"R5/R8 xor step1");
    drive(0,1,1,0,1,0,1,17'h1ffff,2'd2,"R5/R8 xor step2");
    drive(0,1,1,0,1,0,1,17'h00555,2'd3,"R5/R8 xor step3");
    // R10 wrap back to start
    drive(0,1,1,0,1,0,1,17'h00000,2'd0,"R10 xor wrap");
    // R6 hold
    drive(0,1,1,1,1,0,1,17'h0aaaa,2'd2,"R6 hold");
    drive(0,1,1,1,1,0,1,17'h05555,2'd0,"R6 hold");
    // R3 controller strobe, linear order
    drive(0,1,0,1,1,0,0,17'h00abc,2'd2,"R3 ctl load");
    drive(0,1,1,0,1,0,0,17'h00000,2'd0,"R4 lin step");
    drive(0,1,1,0,1,0,0,17'h00000,2'd0,"R4 lin step");
    drive(0,1,1,0,1,0,0,17'h00000,2'd0,"R4 lin step");
    drive(0,1,1,0,1,0,0,17'h00000,2'd0,"R10 lin wrap");
    // R7 strobe beats advance
    drive(0,0,1,0,1,0,0,17'h1ffff,2'd3,"R7 priority");
    drive(0,1,1,0,1,0,0,17'h00000,2'd0,"R4 lin wrap 3->0");
    // R9 deselected strobes
    drive(0,0,1,0,0,0,0,17'h00111,2'd1,"R9 ce low");
    drive(0,1,0,1,1,1,0,17'h00222,2'd2,"R9 ce_n high");
    drive(0,0,0,0,0,1,0,17'h00333,2'd3,"R9 both off");
    // R11 back-to-back loads
    drive(0,0,1,1,1,0,1,17'h10001,2'd0,"R11 b2b");
    drive(0,1,0,1,1,0,1,17'h10002,2'd1,"R11 b2b");
    drive(0,0,0,0,1,0,1,17'h10003,2'd2,"R11 b2b");
    drive(0,1,0,0,1,0,1,17'h10004,2'd3,"R11 b2b");
    // R5 interleaved from offset 2: 3,0,1
    drive(0,0,1,1,1,0,1,17'h0f0f0,2'd2,"R2 load");
    drive(0,1,1,0,1,0,1,17'h00000,2'd0,"R5 xor 2^1");
    drive(0,1,1,0,1,0,1,17'h00000,2'd0,"R5 xor 2^2");
    drive(0,1,1,0,1,0,1,17'h00000,2'd0,"R5 xor 2^3");
    drive(0,1,1,1,1,0,1,17'h00000,2'd0,"R6 hold end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule